// File: doc/BRIEF.md
# Event Number and Readout Word Formatter

The block counts validation pulses in a 32-bit event counter and, for each validated event it accepts, sends up to eight 16-bit parameter words on a valid/ready stream. The counter steps on the trailing edge of every validation pulse. The event number that goes into the readout is the value the counter held at the leading edge of that same pulse. The low four bits of the counter are driven out at all times as a synchronisation tag for the rest of the system.

The words come from sources outside the block and arrive as finished digital values: a trigger-type pattern, a 12-bit timing-converter result and four sum-level words. After the trailing edge, the block waits until the converter-busy input goes low. It then captures all sources together with the enable mask and sends the enabled parameters in ascending index order. Each word carries its 3-bit parameter index, and the final word of the event carries an end flag.

The block has one event slot. It accepts a new event only when that slot is empty. A leading edge that arrives while an earlier event is still waiting or still being sent is counted but is not read out.

Top module: `evnum_readout`

## Requirements
- R1: The event counter is 32 bits wide and resets to 0. It increments by one on every trailing edge of `val_in`, including the pulses that are not read out. A trailing edge is a cycle where `val_in` is sampled low after being sampled high.
- R2: Index 0 carries bits 15:0 and index 1 carries bits 31:16 of the counter value sampled at the leading edge of the accepted pulse. This is the value before that pulse's increment.
- R3: `sync_tag` always equals the low 4 bits of the event counter.
- R4: No word of an event is presented before that pulse's trailing edge. No word is presented while `conv_busy` is high. The sources and `param_en` are captured on the first clock after the trailing edge at which `conv_busy` is low.
- R5: The words are placed by index as follows. Index 2 is `trig_pattern` zero-extended to 16 bits. Index 3 is `conv_value` zero-extended to 16 bits. Indices 4 to 7 are `sum_words` bits 15:0, 31:16, 47:32 and 63:48. Words are sent in strictly ascending index order.
- R6: Bit i of `param_en` enables index i. Disabled indices are skipped, and `out_index` gives the index of each word sent.
- R7: An event captured with `param_en` equal to 0 sends no word.
- R8: `out_last` is 1 on the highest enabled word of an event and 0 on every other word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_index` and `out_last` stay unchanged.
- R10: A leading edge that arrives while an earlier event is waiting for its trailing edge, waiting on `conv_busy`, or still has words to deliver does not start a readout.
- R11: After reset, `out_valid` is 0 and `sync_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_in | input | 1 | Validation pulse level |
| conv_busy | input | 1 | Timing converter still converting |
| param_en | input | 8 | Per-parameter enable, bit i enables index i |
| trig_pattern | input | 8 | Trigger-type pattern |
| conv_value | input | 12 | Timing-converter result |
| sum_words | input | 64 | Four 16-bit sum-level words, level 1 in the low bits |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | Word present |
| out_data | output | 16 | Word value |
| out_index | output | 3 | Parameter index of the word |
| out_last | output | 1 | Last word of the event |
| sync_tag | output | 4 | Low 4 bits of the event counter |

## Verification
Four kinds of event are run: one with all parameters enabled and a ready sink, one with a sparse enable mask under a toggling ready, one with no parameters enabled and one with only the top index enabled. Together these separate errors in ordering, skipping, end-flag placement and backpressure hold. Holding `conv_busy` high after the trailing edge, and sending a second pulse while the first event is still outstanding, shows whether readout is gated correctly and whether an overlapping pulse is counted without being read. A run of more than 65,536 short pulses carries the counter into its upper half. This shows whether index 1 and the leading-edge capture hold the pre-increment value.

// File: rtl/evnum_pkg.sv
package evnum_pkg;
  localparam int NPARAM = 8;
  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(NPARAM);
  localparam int NSUM   = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SETTLE,
    ST_EMIT
  } seq_state_t;
endpackage

// File: rtl/evnum_counter.sv
module evnum_counter #(
  parameter int CNT_W = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             val_in,
  input  logic             arm,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] snap,
  output logic [TAG_W-1:0] sync_tag
);
  logic             val_q;
  logic [CNT_W-1:0] cnt;

  assign rise     = val_in & ~val_q;
  assign fall     = ~val_in & val_q;
  assign sync_tag = cnt[TAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= 1'b0;
      cnt   <= '0;
      snap  <= '0;
    end else begin
      val_q <= val_in;
      if (fall) cnt <= cnt + 1'b1;
      if (arm) snap <= cnt;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(cnt)); // R1
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    fall |=> sync_tag == $past(sync_tag) + 1'b1); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !arm |=> $stable(snap)); // R10
endmodule

// File: rtl/evnum_word_bank.sv
module evnum_word_bank
  import evnum_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIG_W = 8,
  parameter int CONV_W = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          capture,
  input  logic [CNT_W-1:0]              snap,
  input  logic [TRIG_W-1:0]             trig_pattern,
  input  logic [CONV_W-1:0]             conv_value,
  input  logic [NSUM*WORD_W-1:0]        sum_words,
  output logic [NPARAM-1:0][WORD_W-1:0] words
);
  always_ff @(posedge clk) begin
    if (rst) begin
      words[0] <= '0;
      words[1] <= '0;
      words[2] <= '0;
      words[3] <= '0;
    end else if (capture) begin
      words[0] <= snap[WORD_W-1:0];
      words[1] <= snap[2*WORD_W-1:WORD_W];
      words[2] <= WORD_W'(trig_pattern);
      words[3] <= WORD_W'(conv_value);
    end
  end

  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    always_ff @(posedge clk) begin
      if (rst) words[4+g] <= '0;
      else if (capture) words[4+g] <= sum_words[g*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/evnum_sequencer.sv
module evnum_sequencer
  import evnum_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rise,
  input  logic                          fall,
  input  logic                          conv_busy,
  input  logic [NPARAM-1:0]             param_en,
  input  logic [NPARAM-1:0][WORD_W-1:0] words,
  input  logic                          out_ready,
  output logic                          arm,
  output logic                          capture,
  output logic                          out_valid,
  output logic [WORD_W-1:0]             out_data,
  output logic [IDX_W-1:0]              out_index,
  output logic                          out_last
);
  seq_state_t        state;
  logic [NPARAM-1:0] mask;
  logic [NPARAM-1:0] rest;
  logic [IDX_W-1:0]  pick;
  logic              load;

  function automatic logic [IDX_W-1:0] first_set(input logic [NPARAM-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NPARAM - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign arm     = (state == ST_IDLE) && rise;
  assign capture = (state == ST_SETTLE) && !conv_busy;
  assign pick    = first_set(mask);
  assign rest    = mask & ~(NPARAM'(1) << pick);
  assign load    = (state == ST_EMIT) && (mask != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mask      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_index <= '0;
      out_last  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:   if (arm) state <= ST_ARMED;
        ST_ARMED:  if (fall) state <= ST_SETTLE;
        ST_SETTLE: if (capture) begin
          mask  <= param_en;
          state <= (param_en != '0) ? ST_EMIT : ST_IDLE;
        end
        ST_EMIT: begin
          if (load) begin
            out_valid <= 1'b1;
            out_data  <= words[pick];
            out_index <= pick;
            out_last  <= (rest == '0);
            mask      <= rest;
          end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            if (out_last) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_index) && $stable(out_last)); // R9
  AST_WORD_IN_EVENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> state == ST_EMIT); // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid); // R8
endmodule

// File: rtl/evnum_readout.sv
module evnum_readout
  import evnum_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TAG_W  = 4,
  parameter int TRIG_W = 8,
  parameter int CONV_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   val_in,
  input  logic                   conv_busy,
  input  logic [NPARAM-1:0]      param_en,
  input  logic [TRIG_W-1:0]      trig_pattern,
  input  logic [CONV_W-1:0]      conv_value,
  input  logic [NSUM*WORD_W-1:0] sum_words,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [WORD_W-1:0]      out_data,
  output logic [IDX_W-1:0]       out_index,
  output logic                   out_last,
  output logic [TAG_W-1:0]       sync_tag
);
  logic                          rise, fall, arm, capture;
  logic [CNT_W-1:0]              snap;
  logic [NPARAM-1:0][WORD_W-1:0] words;

  evnum_counter #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_cnt (
    .clk(clk), .rst(rst), .val_in(val_in), .arm(arm),
    .rise(rise), .fall(fall), .snap(snap), .sync_tag(sync_tag)
  );

  evnum_word_bank #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .CONV_W(CONV_W)) u_bank (
    .clk(clk), .rst(rst), .capture(capture), .snap(snap),
    .trig_pattern(trig_pattern), .conv_value(conv_value),
    .sum_words(sum_words), .words(words)
  );

  evnum_sequencer u_seq (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .conv_busy(conv_busy),
    .param_en(param_en), .words(words), .out_ready(out_ready),
    .arm(arm), .capture(capture), .out_valid(out_valid), .out_data(out_data),
    .out_index(out_index), .out_last(out_last)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid && sync_tag == '0); // R11
endmodule

// File: tb/evnum_readout_test.sv
module evnum_readout_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        val_in = 1'b0;
  logic        conv_busy = 1'b0;
  logic [7:0]  param_en = 8'h00;
  logic [7:0]  trig_pattern = 8'h00;
  logic [11:0] conv_value = 12'h000;
  logic [63:0] sum_words = 64'h0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_last;
  logic [15:0] out_data;
  logic [2:0]  out_index;
  logic [3:0]  sync_tag;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  // reference model state
  int unsigned m_cnt = 0;
  int unsigned m_latch = 0;
  int m_state = 0;
  bit m_pv = 1'b0;
  bit m_xfer = 1'b0;
  logic [15:0] q_data[$];
  logic [2:0]  q_idx[$];
  bit          q_last[$];
  bit          p_hold = 1'b0;
  logic [15:0] p_data;
  logic [2:0]  p_idx;

  evnum_readout uut (
    .clk(clk), .rst(rst), .val_in(val_in), .conv_busy(conv_busy),
    .param_en(param_en), .trig_pattern(trig_pattern), .conv_value(conv_value),
    .sum_words(sum_words), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_index(out_index), .out_last(out_last),
    .sync_tag(sync_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] word_of(input int i, input int unsigned ev);
    case (i)
      0: return ev[15:0];
      1: return ev[31:16];
      2: return {8'h00, trig_pattern};
      3: return {4'h0, conv_value};
      default: return sum_words[(i-4)*16 +: 16];
    endcase
  endfunction

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
  end

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    bit r, f;
    int top;
    cycles++;
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      finish_run();
    end
    if (rst) begin
      m_cnt = 0; m_latch = 0; m_state = 0; m_pv = 1'b0; m_xfer = 1'b0;
      q_data.delete(); q_idx.delete(); q_last.delete();
    end else begin
      r = val_in && !m_pv;
      f = !val_in && m_pv;
      case (m_state)
        0: if (r) begin m_latch = m_cnt; m_state = 1; end
        1: if (f) m_state = 2;
        2: if (!conv_busy) begin
          top = -1;
          for (int i = 0; i < 8; i++) if (param_en[i]) top = i;
          for (int i = 0; i < 8; i++) begin
            if (param_en[i]) begin
              q_data.push_back(word_of(i, m_latch));
              q_idx.push_back(3'(i));
              q_last.push_back(i == top);
            end
          end
          m_state = (top >= 0) ? 3 : 0;
        end
        default: if (m_xfer) begin
          void'(q_data.pop_front()); void'(q_idx.pop_front()); void'(q_last.pop_front());
          if (q_data.size() == 0) m_state = 0;
        end
      endcase
      m_xfer = 1'b0;
      if (f) m_cnt++;
      m_pv = val_in;
    end
  end

  // comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      if (cycles > 1) begin
        check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
        check(sync_tag == 4'h0, "R11 sync_tag in reset", sync_tag, 0);
      end
    end else begin
      check(sync_tag == m_cnt[3:0], "R3/R1 sync_tag", sync_tag, m_cnt[3:0]);
      if (p_hold)
        check(out_valid && out_data == p_data && out_index == p_idx,
              "R9 word held under backpressure", out_data, p_data);
      if (out_valid) begin
        if (q_data.size() == 0 || m_state != 3) begin
          check(1'b0, "R4/R7/R10 word with no pending event", out_index, 0);
        end else begin
          check(out_index == q_idx[0], "R5/R6 index order", out_index, q_idx[0]);
          check(out_data == q_data[0],
                (q_idx[0] < 2) ? "R2 event number word" : "R5 parameter word",
                out_data, q_data[0]);
          check(out_last == q_last[0], "R8 end flag", out_last, q_last[0]);
          if (out_ready) m_xfer = 1'b1;
        end
      end
      p_hold = out_valid && !out_ready;
      p_data = out_data;
      p_idx  = out_index;
    end
  end

  task automatic pulse(input int hi, input int lo);
    val_in = 1'b1;
    repeat (hi) @(negedge clk);
    val_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R5: all enabled, ready always high
    param_en = 8'hFF; trig_pattern = 8'h3C; conv_value = 12'hABC;
    sum_words = 64'h0034_001A_000D_0041;
    pulse(3, 30);

    // R6 R8 R9 R4: sparse mask, backpressure, converter busy after trailing edge
    ready_mode = 1;
    param_en = 8'b1010_0101; trig_pattern = 8'hC3; conv_value = 12'h123;
    conv_busy = 1'b1;
    pulse(2, 15);
    conv_value = 12'h456;
    conv_busy = 1'b0;
    repeat (50) @(negedge clk);

    // R7: nothing enabled
    param_en = 8'h00;
    pulse(2, 20);

    // R8: only the top index enabled
    param_en = 8'h80; sum_words = 64'hBEEF_0000_0000_0000;
    pulse(1, 20);

    // R10: second pulse while the first waits on the converter
    param_en = 8'h03; conv_busy = 1'b1;
    pulse(2, 4);
    pulse(2, 6);
    conv_busy = 1'b0;
    repeat (40) @(negedge clk);

    // R1 R2: carry the counter into its upper half
    ready_mode = 0;
    param_en = 8'h00;
    for (int k = 0; k < 65540; k++) pulse(1, 1);
    repeat (5) @(negedge clk);
    param_en = 8'h03;
    pulse(2, 30);

    finish_run();
  end
endmodule